// File: doc/BRIEF.md
# Atomic Access Attribute Checker

This block decides whether an atomic memory access may go ahead once its address has been translated. A conditional store and an exclusive load or store are both allowed only if the page's cache attribute permits atomics. That permission comes from a 6-bit atomic-control register. The register packs one 2-bit policy field for each cacheable attribute class. A zero field means that class does not support atomics, and the access must trap.

The checker takes the translation result code, the page read and write rights, the page cache attribute, a flag that says whether a data cache is built in, the access kind and the control register. It decides in combinational logic and registers the verdict one cycle after a request strobe. The registered verdict is a fault flag and a cause code. The surrounding pipeline uses that cause to raise the exception.

Encodings:
- The cache attribute is 3 bits: 0 is bypass, 1 is write-through, 2 is write-back, 3 is isolate, and 4 to 7 are other attributes.
- The access kind is 0 for a conditional store and 1 for an exclusive access.
- The default cause codes are 3 for load/store error, 23 for exclusive error and 29 for store prohibited.

Top module: `atomchk_top`

## Requirements
- R1: The policy field is chosen by attribute from `atom_ctrl`: bits [1:0] for bypass (attribute 0), bits [3:2] for write-through (1) and bits [5:4] for write-back (2). A selected field of zero faults, and a nonzero field passes.
- R2: A policy fault reports the load/store-error cause (3) for a conditional store (`acc_excl`=0) and the exclusive-error cause (23) for an exclusive access (`acc_excl`=1).
- R3: An isolate page (attribute 3) with a data cache present always faults with cause 3, for any `atom_ctrl` value and either access kind.
- R4: With `dcache_present`=0, every attribute, including isolate and attributes 4 to 7, is checked as bypass against bits [1:0].
- R5: A conditional store to a page that does not grant both read and write reports store-prohibited (29). An exclusive access ignores the page rights.
- R6: A nonzero `xlat_code` is reported unchanged as the cause, with a fault, ahead of every other check.
- R7: With a data cache present, attributes 4 to 7 never fault from the attribute check.
- R8: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Without a request, `res_fault` and `res_cause` hold their last values.
- R9: After reset, `res_valid`, `res_fault` and `res_cause` are all zero.
- R10: `acc_write` has no effect on the verdict.
- R11: An accepted access reports `res_fault`=0 and `res_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe; all other inputs are sampled with it |
| xlat_code | input | 6 | Translation result code; 0 means translation succeeded |
| page_read | input | 1 | Page grants read |
| page_write | input | 1 | Page grants write |
| cache_attr | input | 3 | Page cache attribute |
| dcache_present | input | 1 | A data cache is configured |
| acc_excl | input | 1 | 0 = conditional store, 1 = exclusive access |
| acc_write | input | 1 | Exclusive access is a store; does not change the verdict |
| atom_ctrl | input | 6 | Three packed 2-bit atomic policy fields |
| res_valid | output | 1 | Verdict valid, one cycle after the request |
| res_fault | output | 1 | Access must trap |
| res_cause | output | 6 | Exception cause for the trap, 0 when accepted |

## Verification
The hardest cases to reach are the ones where several fault reasons overlap. Examples are a translation fault on an isolate page, a read-only page for a conditional store whose policy field is also zero, and an isolate attribute that is masked because no data cache is present. Only priority separates the outcomes in these cases. The bench therefore sweeps the full cross product of translation code (zero and nonzero), rights, all eight attributes, cache presence, both kinds, the write flag and all 64 control values. It recomputes each verdict arithmetically by shifting the control word by twice the attribute index.

// File: rtl/atomchk_pkg.sv
`timescale 1ns/1ps
package atomchk_pkg;
  localparam int ATTR_W = 3;

  localparam logic [ATTR_W-1:0] ATTR_BYPASS  = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WTHRU   = 3'd1;
  localparam logic [ATTR_W-1:0] ATTR_WBACK   = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_ISOLATE = 3'd3;

  localparam logic KIND_CSTORE = 1'b0;
  localparam logic KIND_EXCL   = 1'b1;

  // policy field index for an attribute class
  function automatic logic [1:0] attr_field_idx(input logic [ATTR_W-1:0] a);
    case (a)
      ATTR_WTHRU: return 2'd1;
      ATTR_WBACK: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  // attribute classes that are governed by a policy field
  function automatic logic attr_has_policy(input logic [ATTR_W-1:0] a);
    return (a == ATTR_BYPASS) || (a == ATTR_WTHRU) || (a == ATTR_WBACK);
  endfunction
endpackage

// File: rtl/atomchk_field_sel.sv
`timescale 1ns/1ps
module atomchk_field_sel #(
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3,
  localparam int CTRL_W    = FIELD_W * NUM_FIELDS,
  localparam int IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [IDX_W-1:0]   idx,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] fields [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_unpack
    assign fields[g] = ctrl[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (idx == IDX_W'(i)) field = fields[i];
    end
  end
endmodule

// File: rtl/atomchk_cause.sv
`timescale 1ns/1ps
module atomchk_cause
  import atomchk_pkg::*;
#(
  parameter int CAUSE_W                  = 6,
  parameter int FIELD_W                  = 2,
  parameter logic [CAUSE_W-1:0] C_LSERR  = 6'd3,
  parameter logic [CAUSE_W-1:0] C_EXCL   = 6'd23,
  parameter logic [CAUSE_W-1:0] C_STPROH = 6'd29
) (
  input  logic [CAUSE_W-1:0] xlat_code,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic [ATTR_W-1:0]  attr_eff,
  input  logic               kind,
  input  logic [FIELD_W-1:0] field,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic               xlat_hit,
  output logic               stproh_hit,
  output logic               isolate_hit,
  output logic               policy_hit
);
  // reasons in strict priority order, each masked by the ones above
  assign xlat_hit    = |xlat_code;
  assign stproh_hit  = !xlat_hit && (kind == KIND_CSTORE) && !(rd_ok && wr_ok);
  assign isolate_hit = !xlat_hit && !stproh_hit && (attr_eff == ATTR_ISOLATE);
  assign policy_hit  = !xlat_hit && !stproh_hit && attr_has_policy(attr_eff)
                       && (field == '0);

  always_comb begin
    fault = 1'b1;
    if (xlat_hit)         cause = xlat_code;
    else if (stproh_hit)  cause = C_STPROH;
    else if (isolate_hit) cause = C_LSERR;
    else if (policy_hit)  cause = (kind == KIND_EXCL) ? C_EXCL : C_LSERR;
    else begin
      fault = 1'b0;
      cause = '0;
    end
  end
endmodule

// File: rtl/atomchk_top.sv
`timescale 1ns/1ps
module atomchk_top
  import atomchk_pkg::*;
#(
  parameter int CAUSE_W                        = 6,
  parameter int FIELD_W                        = 2,
  parameter int NUM_FIELDS                     = 3,
  parameter logic [CAUSE_W-1:0] CAUSE_LS_ERR   = 6'd3,
  parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR = 6'd23,
  parameter logic [CAUSE_W-1:0] CAUSE_ST_PROH  = 6'd29,
  localparam int CTRL_W = FIELD_W * NUM_FIELDS,
  localparam int IDX_W  = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CAUSE_W-1:0] xlat_code,
  input  logic               page_read,
  input  logic               page_write,
  input  logic [ATTR_W-1:0]  cache_attr,
  input  logic               dcache_present,
  input  logic               acc_excl,
  input  logic               acc_write,
  input  logic [CTRL_W-1:0]  atom_ctrl,
  output logic               res_valid,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause
);
  logic [ATTR_W-1:0]  attr_eff;
  logic [IDX_W-1:0]   fidx;
  logic [FIELD_W-1:0] field;
  logic               fault_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               xlat_hit, stproh_hit, isolate_hit, policy_hit;
  logic               unused_acc_write;

  assign unused_acc_write = acc_write;

  // without a data cache every page is checked as bypass
  assign attr_eff = dcache_present ? cache_attr : ATTR_BYPASS;
  assign fidx     = IDX_W'(attr_field_idx(attr_eff));

  atomchk_field_sel #(
    .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)
  ) u_sel (
    .ctrl(atom_ctrl), .idx(fidx), .field(field)
  );

  atomchk_cause #(
    .CAUSE_W(CAUSE_W), .FIELD_W(FIELD_W),
    .C_LSERR(CAUSE_LS_ERR), .C_EXCL(CAUSE_EXCL_ERR), .C_STPROH(CAUSE_ST_PROH)
  ) u_cause (
    .xlat_code(xlat_code), .rd_ok(page_read), .wr_ok(page_write),
    .attr_eff(attr_eff), .kind(acc_excl), .field(field),
    .fault(fault_d), .cause(cause_d),
    .xlat_hit(xlat_hit), .stproh_hit(stproh_hit),
    .isolate_hit(isolate_hit), .policy_hit(policy_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_cause <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_fault <= fault_d;
        res_cause <= cause_d;
      end
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid) else $error("result missing");           // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid) else $error("spurious result");         // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_fault) && $stable(res_cause))
    else $error("verdict changed while idle");                          // R8
  AST_XLAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xlat_hit |=> res_fault && res_cause == $past(xlat_code))
    else $error("translation cause lost");                              // R6
  AST_ISOLATE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && isolate_hit |=> res_fault && res_cause == CAUSE_LS_ERR)
    else $error("isolate not trapped");                                 // R3
  AST_ONE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0({xlat_hit, stproh_hit, isolate_hit, policy_hit}))
    else $error("overlapping reasons");                                 // R6
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_cause == '0)
    else $error("cause on accepted access");                            // R11
endmodule

// File: tb/sim_atomchk_top.sv
`timescale 1ns/1ps
module sim_atomchk_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [5:0] xlat_code = '0;
  logic       page_read = 1'b0, page_write = 1'b0;
  logic [2:0] cache_attr = '0;
  logic       dcache_present = 1'b0, acc_excl = 1'b0, acc_write = 1'b0;
  logic [5:0] atom_ctrl = '0;
  logic       res_valid, res_fault;
  logic [5:0] res_cause;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  atomchk_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xlat_code(xlat_code),
    .page_read(page_read), .page_write(page_write), .cache_attr(cache_attr),
    .dcache_present(dcache_present), .acc_excl(acc_excl), .acc_write(acc_write),
    .atom_ctrl(atom_ctrl), .res_valid(res_valid), .res_fault(res_fault),
    .res_cause(res_cause)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  // one request: drive on a falling edge, sample a full cycle later
  task automatic request(input logic [5:0] xl, input logic rd, input logic wr_r,
                         input logic [2:0] at, input logic dc, input logic ex,
                         input logic aw, input logic [5:0] ctl);
    @(negedge clk);
    xlat_code = xl; page_read = rd; page_write = wr_r; cache_attr = at;
    dcache_present = dc; acc_excl = ex; acc_write = aw; atom_ctrl = ctl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    logic       e_fault;
    logic [5:0] e_cause;
    string      tag;
    int         a;
    int         pol;

    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", {7'd0, res_valid}, 8'd0);
    check("R9 fault", {7'd0, res_fault}, 8'd0);
    check("R9 cause", {2'd0, res_cause}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle valid", {7'd0, res_valid}, 8'd0);

    for (int xi = 0; xi < 2; xi++)
      for (int rw = 0; rw < 4; rw++)
        for (int at = 0; at < 8; at++)
          for (int dc = 0; dc < 2; dc++)
            for (int ex = 0; ex < 2; ex++)
              for (int aw = 0; aw < 2; aw++)
                for (int ctl = 0; ctl < 64; ctl++) begin
                  request(xi ? 6'd9 : 6'd0, rw[0], rw[1], 3'(at), dc[0], ex[0],
                          aw[0], 6'(ctl));
                  a = (dc != 0) ? at : 0;
                  e_fault = 1'b1;
                  if (xi != 0) begin
                    e_cause = 6'd9; tag = "R6";
                  end else if (ex == 0 && rw != 3) begin
                    e_cause = 6'd29; tag = "R5";
                  end else if (a == 3) begin
                    e_cause = 6'd3; tag = "R3";
                  end else if (a < 3) begin
                    pol = (ctl >> (2 * a)) % 4;
                    tag = (dc == 0) ? "R4" : "R1";
                    if (pol == 0) begin
                      e_cause = (ex != 0) ? 6'd23 : 6'd3;
                      tag = {tag, "/R2"};
                    end else begin
                      e_fault = 1'b0; e_cause = 6'd0; tag = {tag, "/R11"};
                    end
                  end else begin
                    e_fault = 1'b0; e_cause = 6'd0; tag = "R7";
                  end
                  if (aw != 0) tag = {tag, "+R10"};
                  check({tag, " valid R8"}, {7'd0, res_valid}, 8'd1);
                  check({tag, " fault"}, {7'd0, res_fault}, {7'd0, e_fault});
                  check({tag, " cause"}, {2'd0, res_cause}, {2'd0, e_cause});
                end

    // R8: verdict holds across idle cycles after a fault
    request(6'd0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 6'b001111);
    repeat (3) begin
      @(negedge clk);
      check("R8 hold valid", {7'd0, res_valid}, 8'd0);
      check("R8 hold fault", {7'd0, res_fault}, 8'd1);
      check("R8 hold cause", {2'd0, res_cause}, 8'd23);
    end

    done = 1'b1;
    finish_run();
  end
endmodule